// File: doc/BRIEF.md
# Switch-Programmed Interval LED Counter

The block counts time in multiples of a fixed base tick and shows a running count on an 8-bit LED word. A bank of slide switches sets the interval at run time: the period is the switch value times the base tick. At each interval boundary the LED word takes the current count and the count then steps by one. The timer reloads itself, so updates repeat at a steady rate with no outside action.

Moving the switches restarts the interval from the new setting and clears the count. Pressing any push button stops the unit for good; only a reset brings it back. The switch and button inputs are asynchronous to the clock and pass through a two-flop synchroniser before any decision uses them. The base tick length in clock cycles is a parameter (10,000,000 cycles for one tenth of a second at 100 MHz).

Top module: `interval_led_counter`

## Requirements
- R1: While reset is asserted and right after it is released, `led_o` is 0 and `run_o` is 1.
- R2: After reset the switch word is captured once, on the third clock edge after release. The first interval ends `sw*TICK_CYC` cycles after that edge, and this first update drives `led_o` to 0.
- R3: The timer reloads itself on expiry, so updates repeat every `sw*TICK_CYC` cycles without outside action.
- R4: On each expiry `led_o` takes the count held before the increment. The count is 8 bits wide and wraps from 255 to 0.
- R5: A change of the switch word stores the new value, restarts the interval from it and sets the count to 0. `led_o` keeps its value until the next expiry, and that expiry drives it to 0.
- R6: When a switch change and an expiry fall in the same cycle, the switch change wins and `led_o` is not updated in that cycle.
- R7: A switch value of 0 gives no period: the timer holds, no expiry occurs and `led_o` keeps its value.
- R8: A nonzero button word halts the unit. `run_o` goes to 0, no further `led_o` update occurs (an expiry in the halting cycle is dropped), and later switch changes have no effect.
- R9: Once halted the unit stays halted, even after the button is released, until a reset. After that reset it runs again from count 0 with a freshly captured switch word.
- R10: Switch and button inputs take effect on the third clock edge after they change, through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_i | input | SW_W | Slide switch word: interval in base ticks |
| btn_i | input | BTN_W | Push buttons; any bit high halts the unit |
| led_o | output | LED_W | LED word: the count before its last increment |
| run_o | output | 1 | 1 while running, 0 once halted |

## Verification
The bench goes after the cycle on which each update lands. A design that is one cycle off in the reload, or that counts the synchroniser delay wrongly, shifts every later LED edge and misses the scheduled samples. It places a switch change exactly on an expiry cycle: a design that lets the expiry win there shows the old count plus one instead of holding. It also drives the count past 255, where a wider or saturating counter shows the wrong value. Finally it sets the switches to zero, where a design that wraps the period counter would fire after 2^SW_W ticks. It also presses the button one cycle after an expiry and moves the switches after the halt, which catches a halt that fires late, that lets a later expiry through, or that a switch change undoes.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    ST_WARM = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } ilc_state_e;
endpackage

// File: rtl/ilc_sync.sv
module ilc_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '0;
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ilc_period_timer.sv
module ilc_period_timer #(
  parameter int unsigned TICK_CYC = 10_000_000,
  parameter int unsigned PER_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             expire_o
);
  localparam int unsigned TICK_W = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICK_CYC - 1);

  logic [TICK_W-1:0] tick_q;
  logic [PER_W-1:0]  unit_q;
  logic              tick_end, unit_end, live;

  assign live     = en_i && (period_i != '0);
  assign tick_end = (tick_q == TICK_LAST);
  assign unit_end = (unit_q == period_i - PER_W'(1));
  assign expire_o = live && tick_end && unit_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      unit_q <= '0;
    end else if (load_i) begin
      tick_q <= '0;
      unit_q <= '0;
    end else if (live) begin
      if (tick_end) begin
        tick_q <= '0;
        unit_q <= unit_end ? '0 : unit_q + PER_W'(1);
      end else begin
        tick_q <= tick_q + TICK_W'(1);
      end
    end
  end
endmodule

// File: rtl/ilc_led_count.sv
module ilc_led_count #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] led_o
);
  logic [W-1:0] cnt_q, led_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      led_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      led_q <= cnt_q;
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign led_o = led_q;
endmodule

// File: rtl/interval_led_counter.sv
module interval_led_counter
  import ilc_pkg::*;
#(
  parameter int unsigned SW_W     = 8,
  parameter int unsigned BTN_W    = 1,
  parameter int unsigned LED_W    = 8,
  parameter int unsigned TICK_CYC = 10_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SW_W-1:0]  sw_i,
  input  logic [BTN_W-1:0] btn_i,
  output logic [LED_W-1:0] led_o,
  output logic             run_o
);
  localparam int unsigned WARM_W = $clog2(SYNC_STAGES + 1);
  localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(SYNC_STAGES);

  logic [SW_W-1:0]   sw_s, sw_last;
  logic [BTN_W-1:0]  btn_s;
  logic [WARM_W-1:0] warm_q;
  ilc_state_e        state_q, state_d;
  logic              halt_req, sw_chg, init_load, tmr_load, tmr_en, tmr_expire, step;

  ilc_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sw_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sw_i), .q_o(sw_s)
  );

  ilc_sync #(.W(BTN_W), .STAGES(SYNC_STAGES)) u_btn_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(btn_i), .q_o(btn_s)
  );

  always_comb begin
    halt_req  = |btn_s;
    sw_chg    = (state_q == ST_RUN) && !halt_req && (sw_s != sw_last);
    init_load = (state_q == ST_WARM) && !halt_req && (warm_q == WARM_LAST);
    tmr_load  = sw_chg || init_load;
    tmr_en    = (state_q == ST_RUN);
    // switch change and halt both outrank an expiry
    step      = tmr_expire && (state_q == ST_RUN) && !halt_req && !sw_chg;

    state_d = state_q;
    unique case (state_q)
      ST_WARM: if (halt_req) state_d = ST_HALT;
               else if (init_load) state_d = ST_RUN;
      ST_RUN:  if (halt_req) state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WARM;
      warm_q  <= '0;
      sw_last <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WARM && warm_q != WARM_LAST) warm_q <= warm_q + WARM_W'(1);
      if (tmr_load) sw_last <= sw_s;
    end
  end

  ilc_period_timer #(.TICK_CYC(TICK_CYC), .PER_W(SW_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .en_i(tmr_en),
    .period_i(sw_last), .expire_o(tmr_expire)
  );

  ilc_led_count #(.W(LED_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_load), .step_i(step), .led_o(led_o)
  );

  assign run_o = (state_q != ST_HALT);
endmodule

// File: rtl/ilc_chk.sv
module ilc_chk #(
  parameter int unsigned SW_W  = 8,
  parameter int unsigned BTN_W = 1,
  parameter int unsigned LED_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_o,
  input logic [LED_W-1:0] led_o,
  input logic             expire_i,
  input logic [SW_W-1:0]  sw_last_i,
  input logic             sw_chg_i,
  input logic [BTN_W-1:0] btn_s_i
);
  // R8
  halt_freezes_led_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |=> $stable(led_o));

  // R9
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_o |=> !run_o);

  // R8
  halt_on_button_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && (btn_s_i != '0)) |=> !run_o);

  // R3
  led_moves_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_o) |-> $past(expire_i));

  // R7
  zero_period_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_last_i == '0) |-> !expire_i);

  // R6
  change_beats_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_chg_i |=> $stable(led_o));
endmodule

bind interval_led_counter ilc_chk #(.SW_W(SW_W), .BTN_W(BTN_W), .LED_W(LED_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_o(run_o), .led_o(led_o),
  .expire_i(tmr_expire), .sw_last_i(sw_last), .sw_chg_i(sw_chg), .btn_s_i(btn_s)
);

// File: tb/sim_interval_led_counter.sv
`timescale 1ns/1ps
module sim_interval_led_counter;
  localparam int TICK = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sw = 8'd3;
  logic [0:0] btn = 1'b0;
  logic [7:0] led;
  logic       run;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  typedef struct {
    int    at;
    int    val;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  interval_led_counter #(.SW_W(8), .BTN_W(1), .LED_W(8), .TICK_CYC(TICK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sw_i(sw), .btn_i(btn), .led_o(led), .run_o(run)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  // monitor: compare LED word against scheduled expectations
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
        n_tests++;
        if (sb_q[0].at < cyc) begin
          n_fail++;
          $display("FAIL %s: item for cycle %0d missed at cycle %0d", sb_q[0].req, sb_q[0].at, cyc);
        end else if (led !== 8'(sb_q[0].val)) begin
          n_fail++;
          $display("FAIL %s: cycle %0d led=%0d expected %0d", sb_q[0].req, cyc, led, sb_q[0].val);
        end
        void'(sb_q.pop_front());
      end
    end
  end

  task automatic push_exp(input int at, input int val, input string req);
    sb_q.push_back('{at, val, req});
  endtask

  // schedule k updates of period n starting at load edge s
  task automatic plan_run(input int s, input int n, input int k, input int prev,
                          input int first, input string req);
    for (int j = 0; j < k; j++) begin
      push_exp(s + n*(j+1) - 1, (j == 0) ? prev : (first + j - 1) % 256, req);
      push_exp(s + n*(j+1), (first + j) % 256, req);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cycle %0d run=%0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic check_led(input int exp, input string req);
    n_tests++;
    if (led !== 8'(exp)) begin
      n_fail++;
      $display("FAIL %s: cycle %0d led=%0d expected %0d", req, cyc, led, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_led(0, "R1");
    check_bit(run, 1'b1, "R1");
    rst_n = 1'b1;
    check_led(0, "R1");
    // R2 R3: sw=3 captured at edge 3, period 12
    plan_run(3, 3*TICK, 4, 0, 0, "R2 R3");
    wait_cyc(55);
    // R5 R10: change to 2, detected at edge 58
    sw = 8'd2;
    push_exp(57, 3, "R10");
    plan_run(58, 2*TICK, 3, 3, 0, "R5 R10");
    wait_cyc(87);
    // R6: change detected on expiry edge 90
    sw = 8'd5;
    push_exp(90, 2, "R6");
    plan_run(90, 5*TICK, 2, 2, 0, "R6");
    wait_cyc(131);
    // R7: zero switches
    sw = 8'd0;
    push_exp(140, 1, "R7");
    push_exp(200, 1, "R7");
    push_exp(300, 1, "R7");
    wait_cyc(301);
    check_bit(run, 1'b1, "R7");
    // R4: period 4, run through wrap
    sw = 8'd1;
    plan_run(304, TICK, 258, 1, 0, "R4");
    wait_cyc(1338);
    // R8: button, halt at edge 1341; expiry at 1340 still lands
    btn = 1'b1;
    push_exp(1340, 2, "R8");
    push_exp(1344, 2, "R8");
    wait_cyc(1340);
    check_bit(run, 1'b1, "R8");
    wait_cyc(1341);
    check_bit(run, 1'b0, "R8");
    wait_cyc(1345);
    sw = 8'd2;
    btn = 1'b0;
    push_exp(1400, 2, "R8");
    wait_cyc(1401);
    check_bit(run, 1'b0, "R9");
    // R9: reset leaves halt
    sw = 8'd1;
    rst_n = 1'b0;
    @(negedge clk);
    check_led(0, "R9");
    check_bit(run, 1'b1, "R9");
    rst_n = 1'b1;
    plan_run(3, TICK, 3, 0, 0, "R9");
    wait_cyc(20);
    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R3: %0d scheduled items left, expected 0", sb_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected end before 20000 cycles");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule